// File: doc/BRIEF.md
# Servo-Loop Code Transition Tracker

This block is the digital half of a feedback loop that locates the analog level at which a converter under test first reaches a chosen output code. A stimulus DAC, driven by this block, feeds the converter. In every sample cycle the block compares the converter's output code with a target code. If the output is below the target, the DAC word goes up by one programmable step. Otherwise it goes down by a second, independent step. Because the DAC word is wider than the converter code, one step is smaller than one converter code width. The loop therefore ends up dithering tightly around the target transition.

The loop counts direction reversals. A run of uninterrupted reversals of programmable length marks the loop as settled. From that cycle on, the DAC word is summed over 2^P cycles. The sum shifted right by P is reported as the transition level, in DAC units, and the loop then freezes. A start pulse loads the initial DAC word and captures every setting. The settings stay fixed until the next start, so software may change the pins freely while a measurement runs.

Top module: `servo_level_tracker`

## Requirements
- R1: After reset, dac_word, settled, level_valid, level and busy are all 0.
- R2: A start pulse sampled at a clock edge makes dac_word equal init_word after that edge. The same edge sets busy and clears settled, level_valid and level.
- R3: While busy, if adc_code is below the captured target code, dac_word rises by the captured up step at the next edge.
- R4: While busy, if adc_code is equal to or above the captured target code, dac_word falls by the captured down step at the next edge.
- R5: dac_word saturates at 0 and at 2^DAC_W-1 and never wraps.
- R6: A reversal is a step whose direction differs from the previous step since start. A step that is not a reversal clears the reversal run. settled rises at the edge of the step that brings the run to the captured target count; a target of 0 acts as 1.
- R7: The average window starts in the first cycle in which settled reads 1 and covers 2^P cycles. The dac_word values present in those cycles are summed, and level becomes the sum shifted right by P, where P is the captured exponent. At the edge that takes the last sample, level_valid rises and busy falls. The loop still takes its step on that edge.
- R8: The target code, both steps, the reversal target and the exponent are sampled only on start. Pin changes during a run have no effect.
- R9: A start during a run abandons it and begins a new one as in R2.
- R10: While busy is 0 and no start is applied, dac_word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a measurement, capture settings |
| init_word | input | DAC_W | DAC word loaded on start |
| ref_code | input | CODE_W | Target code whose transition is sought |
| step_up | input | STEP_W | Increment when output below target |
| step_dn | input | STEP_W | Decrement when output at or above target |
| rev_target | input | REV_W | Consecutive reversals required to settle |
| avg_exp | input | EXP_W | Averaging window exponent P |
| adc_code | input | CODE_W | Output code of the converter under test |
| dac_word | output | DAC_W | Stimulus DAC word |
| settled | output | 1 | Reversal criterion met |
| level_valid | output | 1 | Averaged level available |
| level | output | DAC_W | Averaged transition level in DAC units |
| busy | output | 1 | Loop tracking or averaging |

## Verification
The hardest condition to reach is a reversal run that is interrupted. With equal steps, every step reverses, so the run never breaks. The bench therefore uses unequal up and down steps, so that the loop takes several down steps in a row between single up steps. This clears the run repeatedly and checks the reset-on-no-reversal rule and the settle edge against an independent cycle model. The saturation rails are reached by shifting the behavioural converter threshold so that the target code can never be met, or is always met.

// File: rtl/srv_pkg.sv
package srv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRACK = 2'd1,
    ST_AVG   = 2'd2,
    ST_DONE  = 2'd3
  } srv_state_e;
endpackage

// File: rtl/srv_stepper.sv
module srv_stepper #(
  parameter int DAC_W  = 12,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DAC_W-1:0]  init_word,
  input  logic              step_en,
  input  logic              go_up,
  input  logic [STEP_W-1:0] inc,
  input  logic [STEP_W-1:0] dec,
  output logic [DAC_W-1:0]  word
);
  localparam int SUM_W = DAC_W + 1;
  localparam logic [DAC_W-1:0] WORD_MAX = {DAC_W{1'b1}};

  logic [DAC_W-1:0] word_q, word_d;
  logic [SUM_W-1:0] sum_up;
  logic [DAC_W-1:0] dec_ext;

  always_comb begin
    sum_up  = {1'b0, word_q} + SUM_W'(inc);
    dec_ext = DAC_W'(dec);
    word_d  = word_q;
    if (load) begin
      word_d = init_word;
    end else if (step_en) begin
      if (go_up) begin
        word_d = sum_up[DAC_W] ? WORD_MAX : sum_up[DAC_W-1:0];
      end else begin
        word_d = (word_q < dec_ext) ? '0 : (word_q - dec_ext);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word = word_q;
endmodule

// File: rtl/srv_reversal.sv
module srv_reversal #(
  parameter int REV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step_en,
  input  logic             go_up,
  input  logic [REV_W-1:0] target,
  output logic             hit
);
  logic             prev_up_q, prev_up_d;
  logic             seen_q, seen_d;
  logic [REV_W-1:0] run_q, run_d;
  logic             flip;
  logic [REV_W:0]   run_next;

  always_comb begin
    flip      = step_en && seen_q && (go_up != prev_up_q);
    run_next  = {1'b0, run_q} + 1'b1;
    hit       = flip && (run_next >= {1'b0, target});
    prev_up_d = prev_up_q;
    seen_d    = seen_q;
    run_d     = run_q;
    if (clr) begin
      prev_up_d = 1'b0;
      seen_d    = 1'b0;
      run_d     = '0;
    end else if (step_en) begin
      prev_up_d = go_up;
      seen_d    = 1'b1;
      if (!flip)     run_d = '0;
      else if (!hit) run_d = run_next[REV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_up_q <= 1'b0;
      seen_q    <= 1'b0;
      run_q     <= '0;
    end else begin
      prev_up_q <= prev_up_d;
      seen_q    <= seen_d;
      run_q     <= run_d;
    end
  end
endmodule

// File: rtl/srv_averager.sv
module srv_averager #(
  parameter int DAC_W = 12,
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [DAC_W-1:0] word,
  input  logic [EXP_W-1:0] exp_p,
  output logic             last,
  output logic [DAC_W-1:0] level
);
  localparam int MAXP   = (1 << EXP_W) - 1;
  localparam int ACC_W  = DAC_W + MAXP;
  localparam int SCNT_W = MAXP + 1;

  logic [ACC_W-1:0]  acc_q, acc_d, sum;
  logic [SCNT_W-1:0] scnt_q, scnt_d, limit;
  logic [DAC_W-1:0]  level_q, level_d;

  always_comb begin
    limit   = (SCNT_W'(1) << exp_p) - SCNT_W'(1);
    last    = (scnt_q == limit);
    sum     = acc_q + ACC_W'(word);
    acc_d   = acc_q;
    scnt_d  = scnt_q;
    level_d = level_q;
    if (clr) begin
      acc_d   = '0;
      scnt_d  = '0;
      level_d = '0;
    end else if (en) begin
      acc_d = sum;
      if (last) level_d = DAC_W'(sum >> exp_p);
      else      scnt_d  = scnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      scnt_q  <= '0;
      level_q <= '0;
    end else begin
      acc_q   <= acc_d;
      scnt_q  <= scnt_d;
      level_q <= level_d;
    end
  end

  assign level = level_q;
endmodule

// File: rtl/servo_level_tracker.sv
module servo_level_tracker
  import srv_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int DAC_W  = 12,
  parameter int STEP_W = 8,
  parameter int REV_W  = 6,
  parameter int EXP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DAC_W-1:0]  init_word,
  input  logic [CODE_W-1:0] ref_code,
  input  logic [STEP_W-1:0] step_up,
  input  logic [STEP_W-1:0] step_dn,
  input  logic [REV_W-1:0]  rev_target,
  input  logic [EXP_W-1:0]  avg_exp,
  input  logic [CODE_W-1:0] adc_code,
  output logic [DAC_W-1:0]  dac_word,
  output logic              settled,
  output logic              level_valid,
  output logic [DAC_W-1:0]  level,
  output logic              busy
);
  srv_state_e        st_q, st_d;
  logic [CODE_W-1:0] ref_q;
  logic [STEP_W-1:0] inc_q, dec_q;
  logic [REV_W-1:0]  tgt_q;
  logic [EXP_W-1:0]  exp_q;
  logic              settled_q, settled_d;
  logic              valid_q, valid_d;
  logic              running, step_en, go_up, hit, last, avg_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      inc_q <= '0;
      dec_q <= '0;
      tgt_q <= '0;
      exp_q <= '0;
    end else if (start) begin
      ref_q <= ref_code;
      inc_q <= step_up;
      dec_q <= step_dn;
      tgt_q <= rev_target;
      exp_q <= avg_exp;
    end
  end

  always_comb begin
    running = (st_q == ST_TRACK) || (st_q == ST_AVG);
    step_en = running && !start;
    go_up   = (adc_code < ref_q);
    avg_en  = (st_q == ST_AVG) && !start;
  end

  always_comb begin
    st_d      = st_q;
    settled_d = settled_q;
    valid_d   = valid_q;
    if (start) begin
      st_d      = ST_TRACK;
      settled_d = 1'b0;
      valid_d   = 1'b0;
    end else begin
      unique case (st_q)
        ST_TRACK: if (hit) begin
          st_d      = ST_AVG;
          settled_d = 1'b1;
        end
        ST_AVG: if (last) begin
          st_d    = ST_DONE;
          valid_d = 1'b1;
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      settled_q <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      st_q      <= st_d;
      settled_q <= settled_d;
      valid_q   <= valid_d;
    end
  end

  srv_stepper #(.DAC_W(DAC_W), .STEP_W(STEP_W)) u_stepper (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .init_word (init_word),
    .step_en   (step_en),
    .go_up     (go_up),
    .inc       (inc_q),
    .dec       (dec_q),
    .word      (dac_word)
  );

  srv_reversal #(.REV_W(REV_W)) u_reversal (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start),
    .step_en (step_en),
    .go_up   (go_up),
    .target  (tgt_q),
    .hit     (hit)
  );

  srv_averager #(.DAC_W(DAC_W), .EXP_W(EXP_W)) u_averager (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start),
    .en    (avg_en),
    .word  (dac_word),
    .exp_p (exp_q),
    .last  (last),
    .level (level)
  );

  assign settled     = settled_q;
  assign level_valid = valid_q;
  assign busy        = running;
endmodule

// File: rtl/srv_tracker_chk.sv
module srv_tracker_chk #(
  parameter int CODE_W = 8,
  parameter int DAC_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [DAC_W-1:0]  init_word,
  input logic [CODE_W-1:0] adc_code,
  input logic [CODE_W-1:0] ref_q,
  input logic [DAC_W-1:0]  dac_word,
  input logic              busy,
  input logic              settled,
  input logic              level_valid
);
  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (dac_word == $past(init_word)) && busy && !settled && !level_valid); // R2

  AST_UP_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && (adc_code < ref_q)) |=> (dac_word >= $past(dac_word))); // R3

  AST_DN_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && (adc_code >= ref_q)) |=> (dac_word <= $past(dac_word))); // R4

  AST_SETTLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(level_valid) |-> $past(settled)); // R6

  AST_VALID_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    level_valid |-> (settled && !busy)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(dac_word)); // R10
endmodule

bind servo_level_tracker srv_tracker_chk #(.CODE_W(CODE_W), .DAC_W(DAC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .init_word   (init_word),
  .adc_code    (adc_code),
  .ref_q       (ref_q),
  .dac_word    (dac_word),
  .busy        (busy),
  .settled     (settled),
  .level_valid (level_valid)
);

// File: tb/servo_level_tracker_bench.sv
module servo_level_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W = 8;
  localparam int DAC_W  = 12;
  localparam int STEP_W = 8;
  localparam int REV_W  = 6;
  localparam int EXP_W  = 4;
  localparam int SHIFT  = DAC_W - CODE_W;
  localparam int WMAX   = (1 << DAC_W) - 1;
  localparam int CMAX   = (1 << CODE_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [DAC_W-1:0]  init_word;
  logic [CODE_W-1:0] ref_code;
  logic [STEP_W-1:0] step_up, step_dn;
  logic [REV_W-1:0]  rev_target;
  logic [EXP_W-1:0]  avg_exp;
  logic [CODE_W-1:0] adc_code;
  logic [DAC_W-1:0]  dac_word;
  logic              settled, level_valid, busy;
  logic [DAC_W-1:0]  level;

  int offs;
  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit cmp_en = 1'b0;
  string cur_tag = "R1";

  // model state
  int m_st, m_w, m_ref, m_inc, m_dec, m_tgt, m_p;
  int m_prev, m_seen, m_cnt, m_scnt, m_set, m_val, m_lvl;
  longint m_acc;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int code_of(int w, int off);
    int v;
    v = w + off;
    if (v < 0) v = 0;
    v = v >> SHIFT;
    if (v > CMAX) v = CMAX;
    return v;
  endfunction

  assign adc_code = CODE_W'(code_of(int'(dac_word), offs));

  servo_level_tracker #(
    .CODE_W(CODE_W), .DAC_W(DAC_W), .STEP_W(STEP_W), .REV_W(REV_W), .EXP_W(EXP_W)
  ) u_servo_level_tracker (
    .clk(clk), .rst_n(rst_n), .start(start), .init_word(init_word),
    .ref_code(ref_code), .step_up(step_up), .step_dn(step_dn),
    .rev_target(rev_target), .avg_exp(avg_exp), .adc_code(adc_code),
    .dac_word(dac_word), .settled(settled), .level_valid(level_valid),
    .level(level), .busy(busy)
  );

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_w = 0; m_ref = 0; m_inc = 0; m_dec = 0; m_tgt = 0; m_p = 0;
      m_prev = 0; m_seen = 0; m_cnt = 0; m_scnt = 0; m_set = 0; m_val = 0;
      m_lvl = 0; m_acc = 0;
    end else if (start) begin
      m_st = 1; m_w = int'(init_word); m_ref = int'(ref_code);
      m_inc = int'(step_up); m_dec = int'(step_dn); m_tgt = int'(rev_target);
      m_p = int'(avg_exp); m_prev = 0; m_seen = 0; m_cnt = 0; m_scnt = 0;
      m_set = 0; m_val = 0; m_lvl = 0; m_acc = 0;
    end else if (m_st == 1 || m_st == 2) begin
      int u, rev, oldw, ost;
      ost  = m_st;
      oldw = m_w;
      u    = (code_of(m_w, offs) < m_ref) ? 1 : 0;
      rev  = (m_seen != 0 && u != m_prev) ? 1 : 0;
      if (u != 0) m_w = (m_w + m_inc > WMAX) ? WMAX : m_w + m_inc;
      else        m_w = (m_w < m_dec) ? 0 : m_w - m_dec;
      m_prev = u;
      m_seen = 1;
      if (ost == 1) begin
        if (rev != 0) begin
          if (m_cnt + 1 >= m_tgt) begin m_st = 2; m_set = 1; end
          else m_cnt = m_cnt + 1;
        end else m_cnt = 0;
      end else begin
        m_acc = m_acc + oldw;
        if (m_scnt == (1 << m_p) - 1) begin
          m_lvl = int'(m_acc >>> m_p); m_val = 1; m_st = 3;
        end else m_scnt = m_scnt + 1;
      end
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      check(cur_tag, "dac_word", int'(dac_word), m_w);
      check("R6", "settled", int'(settled), m_set);
      check("R7", "level_valid", int'(level_valid), m_val);
      check("R7", "level", int'(level), m_lvl);
      check("R2", "busy", int'(busy), (m_st == 1 || m_st == 2) ? 1 : 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 150000);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic launch(int iw, int rc, int su, int sd, int rt, int ap);
    @(negedge clk);
    init_word = DAC_W'(iw); ref_code = CODE_W'(rc); step_up = STEP_W'(su);
    step_dn = STEP_W'(sd); rev_target = REV_W'(rt); avg_exp = EXP_W'(ap);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(string tag);
    int k = 0;
    while (!level_valid && k < 5000) begin @(negedge clk); k++; end
    check(tag, "completion", int'(level_valid), 1);
  endtask

  task automatic near(string tag, int t, int tol);
    int d;
    d = int'(level) - t;
    if (d < 0) d = -d;
    check(tag, "level distance to threshold", (d <= tol) ? 1 : 0, 1);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; init_word = '0; ref_code = '0; step_up = '0;
    step_dn = '0; rev_target = '0; avg_exp = '0; offs = 5;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "dac_word", int'(dac_word), 0);
    check("R1", "settled", int'(settled), 0);
    check("R1", "level_valid", int'(level_valid), 0);
    check("R1", "level", int'(level), 0);
    check("R1", "busy", int'(busy), 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    // R10: idle with changing pins, no start
    cur_tag = "R10";
    init_word = 12'd999; ref_code = 8'd77;
    repeat (5) @(negedge clk);
    check("R10", "idle dac_word", int'(dac_word), 0);

    // R3 R4 R6 R7: equal steps, target 40 -> threshold 640-5
    cur_tag = "R3";
    launch(600, 40, 3, 3, 4, 3);
    check("R2", "loaded word", int'(dac_word), 600);
    wait_done("R7");
    near("R7", 635, 3);
    repeat (6) @(negedge clk);
    check("R10", "frozen after done", int'(dac_word), m_w);

    // R4 R6: unequal steps break reversal runs
    cur_tag = "R4";
    offs = -7;
    launch(1200, 90, 5, 2, 2, 4);
    wait_done("R6");
    near("R6", 1447, 5);

    // R6: target zero behaves as one
    cur_tag = "R6";
    offs = 0;
    launch(300, 20, 4, 4, 0, 0);
    wait_done("R6");
    near("R6", 320, 4);

    // R8: pins disturbed right after start
    cur_tag = "R8";
    offs = 3;
    launch(2000, 130, 6, 6, 3, 2);
    ref_code = 8'd10; step_up = 8'd200; step_dn = 8'd1; rev_target = 6'd50;
    avg_exp = 4'd9; init_word = 12'd5;
    wait_done("R8");
    near("R8", 2077, 6);

    // R5: upper rail, target never reached
    cur_tag = "R5";
    offs = -32;
    launch(4000, 255, 200, 3, 4, 2);
    repeat (10) @(negedge clk);
    check("R5", "upper rail", int'(dac_word), WMAX);
    check("R5", "still tracking", int'(busy), 1);
    // R5: lower rail, target always met
    offs = 0;
    launch(5, 0, 3, 7, 4, 2);
    repeat (5) @(negedge clk);
    check("R5", "lower rail", int'(dac_word), 0);

    // R9: restart mid-average
    cur_tag = "R9";
    launch(600, 40, 2, 2, 2, 6);
    repeat (40) @(negedge clk);
    launch(3000, 180, 8, 8, 3, 1);
    check("R9", "reloaded word", int'(dac_word), 3000);
    check("R9", "settled cleared", int'(settled), 0);
    wait_done("R9");
    near("R9", 2880, 8);

    cmp_en = 1'b0;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule